// File: doc/BRIEF.md
# Shared-Latency Write Arbiter for a Line-Organised Memory

This block is a small word-addressed memory organised as lines of four words. Three requesters share its write path: a memory stage, an instruction fetch stage and a first-level cache. Each one presents a write and keeps presenting it until the block answers OK. The block keeps an ordered list of the requesters that are waiting. Only the oldest entry in that list can finish, and it finishes only after one shared access latency has run down. Any other requester that presents a write in that cycle gets WAIT.

A fourth, privileged port writes at once. It skips both the queue and the latency and always answers OK. A separate view port returns one whole line combinationally for inspection. It has no effect on arbitration.

Status codes come back combinationally in the same cycle, so a requester knows before the clock edge whether its write commits at that edge. A third code, BLOCKED, is reserved in the encoding. This version never drives it.

Top module: `amq_shared_mem`

## Requirements
- R1: A word address splits into a line index (the address bits above the two lowest, i.e. address / 4) and a word index (the two lowest bits, i.e. address mod 4), so flat word address A lands in view line A/4, word A mod 4.
- R2: After reset every word of the array reads zero, the queue is empty and the latency counter holds the configured delay.
- R3: A side-port write reports OK in the cycle it is presented, whatever the state of the queue or counter, and the written word is visible on the view port from the next cycle.
- R4: Waiting requesters complete strictly in order of arrival. Requesters that arrive in the same cycle are ordered memory stage, then fetch, then cache.
- R5: A requester already in the queue is not added a second time when it presents again. The requester behind it therefore waits only one latency period after the first one completes.
- R6: Only the requester at the head of the queue can get OK, and only in a cycle where the counter is zero and that requester presents its write. Its write commits at that clock edge, and every other presenting requester gets WAIT.
- R7: Starting from an empty queue with delay N, a requester that presents every cycle sees WAIT for N cycles and OK on presentation N+1.
- R8: At each clock edge with a non-empty queue, a zero counter pops the head and reloads the delay; otherwise the counter counts down by one. While the queue is empty the counter holds, so a later request again sees N+1 presentations.
- R9: At most one normal requester gets OK in a cycle, no port ever reports BLOCKED, and a port that presents nothing reports WAIT.
- R10: The view port returns all four words of the selected line in the same cycle, independent of the queue.
- R11: If the side port and a completing normal write target the same word in the same cycle, the side-port data is what the array keeps.
- R12: Status encoding is OK = 2'd0, WAIT = 2'd1, BLOCKED = 2'd2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Write presented, one bit per requester (0 memory stage, 1 fetch, 2 cache) |
| req_addr | input | NREQ x ADDR_W | Word address for each requester |
| req_data | input | NREQ x WORD_W | Write data for each requester |
| req_status | output | NREQ x 2 | Per-requester status (OK/WAIT/BLOCKED) |
| side_valid | input | 1 | Privileged immediate write |
| side_addr | input | ADDR_W | Side-port word address |
| side_data | input | WORD_W | Side-port write data |
| side_status | output | 2 | Side-port status |
| view_line | input | LINE_W | Line selected for inspection |
| view_data | output | LINE_WORDS x WORD_W | All words of the selected line |

## Verification
The assertions assume that every requester holds its valid bit, address and data steady from its first presentation until the cycle it sees OK. If a queued requester withdraws, it would still be popped as head without committing, and the ordering properties would lose their meaning. The stimulus keeps a pending flag per requester. It drives the write on every cycle until the reference model grants it, and clears it only at that edge. Side-port writes last one cycle and may land at any time, including on the word that a normal write is committing in the same cycle.

// File: rtl/amq_pkg.sv
package amq_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_WAIT    = 2'd1,
    ST_BLOCKED = 2'd2
  } status_e;

  localparam int SRC_MEM   = 0;
  localparam int SRC_FETCH = 1;
  localparam int SRC_L1    = 2;
endpackage

// File: rtl/amq_fcfs_queue.sv
module amq_fcfs_queue #(
  parameter int NREQ = 3,
  localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1,
  localparam int CW  = $clog2(NREQ + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] arrive,
  input  logic            pop,
  output logic [IDW-1:0]  head_id,
  output logic            busy
);
  logic [IDW-1:0] slot_q [NREQ];
  logic [IDW-1:0] slot_e [NREQ];
  logic [IDW-1:0] slot_d [NREQ];
  logic [NREQ-1:0] held_q, held_e, held_d;
  logic [CW-1:0]   cnt_q, cnt_e, cnt_d;

  // Append new arrivals in index order, then apply the pop.
  always_comb begin
    slot_e = slot_q;
    held_e = held_q;
    cnt_e  = cnt_q;
    for (int i = 0; i < NREQ; i++) begin
      if (arrive[i] && !held_q[i] && (cnt_e < CW'(NREQ))) begin
        slot_e[cnt_e[IDW-1:0]] = IDW'(i);
        held_e[i] = 1'b1;
        cnt_e = cnt_e + 1'b1;
      end
    end
    slot_d = slot_e;
    held_d = held_e;
    cnt_d  = cnt_e;
    if (pop && (cnt_e != '0)) begin
      for (int k = 0; k < NREQ - 1; k++) slot_d[k] = slot_e[k+1];
      held_d[slot_e[0]] = 1'b0;
      cnt_d = cnt_e - 1'b1;
    end
  end

  assign busy    = (cnt_e != '0);
  assign head_id = slot_e[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREQ; k++) slot_q[k] <= '0;
      held_q <= '0;
      cnt_q  <= '0;
    end else begin
      slot_q <= slot_d;
      held_q <= held_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/amq_wait_timer.sv
module amq_wait_timer #(
  parameter int DELAY = 3,
  localparam int TW = (DELAY > 0) ? $clog2(DELAY + 1) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  output logic zero
);
  logic [TW-1:0] cnt_q;

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= TW'(DELAY);
    else if (busy && zero)  cnt_q <= TW'(DELAY);
    else if (busy)          cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/amq_line_store.sv
module amq_line_store #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 16,
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int ADDR_W = LINE_W + WSEL_W
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wa_en,
  input  logic [ADDR_W-1:0]                  wa_addr,
  input  logic [WORD_W-1:0]                  wa_data,
  input  logic                               wb_en,
  input  logic [ADDR_W-1:0]                  wb_addr,
  input  logic [WORD_W-1:0]                  wb_data,
  input  logic [LINE_W-1:0]                  view_line,
  output logic [LINE_WORDS-1:0][WORD_W-1:0]  view_data
);
  logic [LINE_WORDS-1:0][WORD_W-1:0] mem_q [NUM_LINES];

  logic [LINE_W-1:0] a_line, b_line;
  logic [WSEL_W-1:0] a_word, b_word;

  assign a_line = wa_addr[ADDR_W-1:WSEL_W];
  assign a_word = wa_addr[WSEL_W-1:0];
  assign b_line = wb_addr[ADDR_W-1:WSEL_W];
  assign b_word = wb_addr[WSEL_W-1:0];

  // Port b is written last so it wins a same-word collision.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < NUM_LINES; l++) mem_q[l] <= '0;
    end else begin
      if (wa_en) mem_q[a_line][a_word] <= wa_data;
      if (wb_en) mem_q[b_line][b_word] <= wb_data;
    end
  end

  assign view_data = mem_q[view_line];
endmodule

// File: rtl/amq_shared_mem.sv
module amq_shared_mem
  import amq_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 16,
  parameter int NREQ       = 3,
  parameter int DELAY      = 3,
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int ADDR_W = LINE_W + $clog2(LINE_WORDS),
  localparam int IDW    = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NREQ-1:0]                   req_valid,
  input  logic [NREQ-1:0][ADDR_W-1:0]       req_addr,
  input  logic [NREQ-1:0][WORD_W-1:0]       req_data,
  output logic [NREQ-1:0][1:0]              req_status,
  input  logic                              side_valid,
  input  logic [ADDR_W-1:0]                 side_addr,
  input  logic [WORD_W-1:0]                 side_data,
  output logic [1:0]                        side_status,
  input  logic [LINE_W-1:0]                 view_line,
  output logic [LINE_WORDS-1:0][WORD_W-1:0] view_data
);
  logic [IDW-1:0] head_id;
  logic           busy, zero, pop, grant;

  amq_fcfs_queue #(.NREQ(NREQ)) u_queue (
    .clk(clk), .rst(rst), .arrive(req_valid), .pop(pop),
    .head_id(head_id), .busy(busy)
  );

  amq_wait_timer #(.DELAY(DELAY)) u_timer (
    .clk(clk), .rst(rst), .busy(busy), .zero(zero)
  );

  assign pop   = busy & zero;
  assign grant = pop & req_valid[head_id];

  for (genvar i = 0; i < NREQ; i++) begin : g_status
    assign req_status[i] = (grant && (head_id == IDW'(i))) ? ST_OK : ST_WAIT;
  end

  assign side_status = side_valid ? ST_OK : ST_WAIT;

  amq_line_store #(
    .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)
  ) u_store (
    .clk(clk), .rst(rst),
    .wa_en(grant), .wa_addr(req_addr[head_id]), .wa_data(req_data[head_id]),
    .wb_en(side_valid), .wb_addr(side_addr), .wb_data(side_data),
    .view_line(view_line), .view_data(view_data)
  );
endmodule

// File: rtl/amq_shared_mem_chk.sv
module amq_shared_mem_chk #(
  parameter int NREQ  = 3,
  parameter int DELAY = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NREQ-1:0]      req_valid,
  input logic [NREQ-1:0][1:0] req_status,
  input logic                 side_valid,
  input logic [1:0]           side_status
);
  logic [NREQ-1:0] ok_vec;
  logic            any_blocked;

  always_comb begin
    any_blocked = (side_status == 2'd2);
    for (int i = 0; i < NREQ; i++) begin
      ok_vec[i] = (req_status[i] == 2'd0);
      if (req_status[i] == 2'd2) any_blocked = 1'b1;
    end
  end

  AST_SIDE_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    side_valid |-> side_status == 2'd0); // R3
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $countones(ok_vec) <= 1); // R9
  AST_NO_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    !any_blocked); // R9
  AST_GRANT_GAP: assert property (@(posedge clk) disable iff (rst)
    ((DELAY > 0) && (ok_vec != '0)) |=> (ok_vec == '0)); // R8

  for (genvar i = 0; i < NREQ; i++) begin : g_port
    AST_IDLE_WAIT: assert property (@(posedge clk) disable iff (rst)
      !req_valid[i] |-> req_status[i] == 2'd1); // R9
    AST_OK_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
      ok_vec[i] |-> req_valid[i]); // R6
  end
endmodule

bind amq_shared_mem amq_shared_mem_chk #(.NREQ(NREQ), .DELAY(DELAY)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_status(req_status),
  .side_valid(side_valid), .side_status(side_status)
);

// File: tb/sim_amq_shared_mem.sv
module sim_amq_shared_mem;
  localparam int WORD_W = 32, LINE_WORDS = 4, NUM_LINES = 16, NREQ = 3, DELAY = 3;
  localparam int LINE_W = 4, ADDR_W = 6, NWORDS = NUM_LINES * LINE_WORDS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [NREQ-1:0]                   req_valid = '0;
  logic [NREQ-1:0][ADDR_W-1:0]       req_addr = '0;
  logic [NREQ-1:0][WORD_W-1:0]       req_data = '0;
  logic [NREQ-1:0][1:0]              req_status;
  logic                              side_valid = 1'b0;
  logic [ADDR_W-1:0]                 side_addr = '0;
  logic [WORD_W-1:0]                 side_data = '0;
  logic [1:0]                        side_status;
  logic [LINE_W-1:0]                 view_line = '0;
  logic [LINE_WORDS-1:0][WORD_W-1:0] view_data;

  amq_shared_mem #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES),
                   .NREQ(NREQ), .DELAY(DELAY)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_status(req_status), .side_valid(side_valid),
    .side_addr(side_addr), .side_data(side_data), .side_status(side_status),
    .view_line(view_line), .view_data(view_data));

  int errors = 0, checks = 0;
  string tag = "R2";
  bit pend [NREQ];
  logic [ADDR_W-1:0] paddr [NREQ];
  logic [WORD_W-1:0] pdata [NREQ];
  bit sv = 1'b0;
  logic [ADDR_W-1:0] sa = '0;
  logic [WORD_W-1:0] sd = '0;
  logic [LINE_W-1:0] vl = '0;
  int mq[$];
  int mcnt = DELAY;
  logic [WORD_W-1:0] mmem [NWORDS];
  int last_grant = -1;
  int grant_log[$];

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    int eq[$];
    int g;
    bit seen;
    @(negedge clk);
    for (int i = 0; i < NREQ; i++) begin
      req_valid[i] = pend[i];
      req_addr[i]  = paddr[i];
      req_data[i]  = pdata[i];
    end
    side_valid = sv; side_addr = sa; side_data = sd; view_line = vl;
    #1;
    eq = mq;
    for (int i = 0; i < NREQ; i++) begin
      seen = 1'b0;
      foreach (mq[k]) if (mq[k] == i) seen = 1'b1;
      if (pend[i] && !seen) eq.push_back(i);
    end
    g = -1;
    if (eq.size() > 0 && mcnt == 0 && pend[eq[0]]) g = eq[0];
    last_grant = -1;
    for (int i = 0; i < NREQ; i++) begin
      chk(req_status[i] == ((i == g) ? 2'd0 : 2'd1), tag, $sformatf("status of requester %0d", i),
          64'(req_status[i]), (i == g) ? 64'd0 : 64'd1);
      chk(req_status[i] != 2'd2, "R9", "BLOCKED driven", 64'(req_status[i]), 64'd1);
      if (req_status[i] == 2'd0) last_grant = i;
    end
    if (last_grant >= 0) grant_log.push_back(last_grant);
    chk(side_status == (sv ? 2'd0 : 2'd1), "R3", "side status", 64'(side_status), sv ? 64'd0 : 64'd1);
    for (int w = 0; w < LINE_WORDS; w++)
      chk(view_data[w] == mmem[int'(vl) * LINE_WORDS + w], "R10", $sformatf("view line %0d word %0d", vl, w),
          64'(view_data[w]), 64'(mmem[int'(vl) * LINE_WORDS + w]));
    @(posedge clk);
    if (g >= 0) begin
      mmem[paddr[g]] = pdata[g];
      pend[g] = 1'b0;
    end
    if (sv) mmem[sa] = sd;
    sv = 1'b0;
    if (eq.size() > 0) begin
      if (mcnt == 0) begin
        void'(eq.pop_front());
        mcnt = DELAY;
      end else mcnt--;
    end
    mq = eq;
  endtask

  task automatic drain();
    int guard = 0;
    while ((pend[0] || pend[1] || pend[2]) && guard < 100) begin
      step();
      guard++;
    end
  endtask

  task automatic post(int r, int a, logic [WORD_W-1:0] d);
    pend[r] = 1'b1; paddr[r] = ADDR_W'(a); pdata[r] = d;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int n;
    int exp_order[$];
    for (int i = 0; i < NREQ; i++) begin
      pend[i] = 1'b0; paddr[i] = '0; pdata[i] = '0;
    end
    for (int k = 0; k < NWORDS; k++) mmem[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R2 / R12: reset contents and idle encoding
    tag = "R2";
    for (int l = 0; l < NUM_LINES; l++) begin
      vl = LINE_W'(l);
      step();
    end
    chk(req_status[0] == 2'd1, "R12", "idle WAIT code", 64'(req_status[0]), 64'd1);

    // R7: latency from an empty queue
    tag = "R7";
    post(0, 0, 32'h11223344);
    n = 0;
    do begin step(); n++; end while (last_grant != 0 && n < 20);
    chk(n == DELAY + 1, "R7", "presentations until OK", 64'(n), 64'(DELAY + 1));
    chk(req_status[0] == 2'd0, "R12", "OK code", 64'(req_status[0]), 64'd0);

    // R8: counter holds while idle
    tag = "R8";
    repeat (5) step();
    post(1, 5, 32'hA5A5_0005);
    n = 0;
    do begin step(); n++; end while (last_grant != 1 && n < 20);
    chk(n == DELAY + 1, "R8", "presentations after idle gap", 64'(n), 64'(DELAY + 1));

    // R5: re-presenting requester not duplicated
    tag = "R5";
    post(1, 1, 32'h0000_F001);
    step();
    post(0, 2, 32'h0000_E002);
    n = 0;
    do begin step(); n++; end while (last_grant != 0 && n < 30);
    chk(n == 2 * (DELAY + 1) - 1, "R5", "second-in-line presentations", 64'(n), 64'(2 * (DELAY + 1) - 1));

    // R4: simultaneous arrivals in fixed priority
    tag = "R4";
    grant_log.delete();
    post(0, 16, 32'h1); post(1, 17, 32'h2); post(2, 18, 32'h3);
    drain();
    exp_order = '{0, 1, 2};
    chk(grant_log.size() == 3, "R4", "grant count", 64'(grant_log.size()), 64'd3);
    foreach (exp_order[k])
      if (k < grant_log.size())
        chk(grant_log[k] == exp_order[k], "R4", "simultaneous order", 64'(grant_log[k]), 64'(exp_order[k]));

    // R4: staggered arrivals served in arrival order
    grant_log.delete();
    post(2, 20, 32'h20); step();
    post(0, 21, 32'h21); step();
    post(1, 22, 32'h22);
    drain();
    exp_order = '{2, 0, 1};
    chk(grant_log.size() == 3, "R4", "grant count", 64'(grant_log.size()), 64'd3);
    foreach (exp_order[k])
      if (k < grant_log.size())
        chk(grant_log[k] == exp_order[k], "R4", "arrival order", 64'(grant_log[k]), 64'(exp_order[k]));

    // R6: contention, only head completes
    tag = "R6";
    post(0, 24, 32'h6000_0000); post(2, 25, 32'h6000_0002);
    step();
    post(1, 26, 32'h6000_0001);
    drain();

    // R11: side wins same-word collision
    tag = "R11";
    post(2, 9, 32'hAAAA_0009);
    repeat (DELAY) step();
    sv = 1'b1; sa = 6'd9; sd = 32'hBBBB_0009;
    step();
    vl = 4'd2;
    step();
    chk(view_data[1] == 32'hBBBB_0009, "R11", "collided word", 64'(view_data[1]), 64'hBBBB_0009);

    // R3: side write while the queue is busy
    tag = "R3";
    post(0, 12, 32'h0C0C_0C0C);
    step();
    sv = 1'b1; sa = 6'd13; sd = 32'hCAFE_000D;
    step();
    vl = 4'd3;
    step();
    chk(view_data[1] == 32'hCAFE_000D, "R3", "side word visible", 64'(view_data[1]), 64'hCAFE_000D);
    chk(pend[0] == 1'b1, "R3", "normal writer still waiting", 64'(pend[0]), 64'd1);
    drain();

    // R1: address split
    tag = "R1";
    sv = 1'b1; sa = 6'd6; sd = 32'hD00D_0006;
    step();
    vl = 4'd1;
    step();
    chk(view_data[2] == 32'hD00D_0006, "R1", "line 1 word 2", 64'(view_data[2]), 64'hD00D_0006);

    // R10 / R9: mixed traffic with a moving view
    tag = "R9";
    for (int c = 0; c < 400; c++) begin
      for (int i = 0; i < NREQ; i++)
        if (!pend[i] && ($urandom % 4 == 0)) post(i, int'($urandom % NWORDS), $urandom);
      if ($urandom % 8 == 0) begin
        sv = 1'b1; sa = ADDR_W'($urandom % NWORDS); sd = $urandom;
      end
      vl = LINE_W'($urandom % NUM_LINES);
      step();
    end
    drain();

    summary();
    $finish;
  end
endmodule